// File: doc/BRIEF.md
# Receive Word Buffer with Per-Word Error Flags

This block sits between a serial receiver's shift register and a processor-facing register interface. Each time the receiver completes a word, it presents the word together with the word's framing-error, parity-error and noise indications. The block keeps up to two complete words in a small first-in first-out store. Each stored word carries its own framing and parity bits, so the status seen by software always belongs to the word that the next data read will return.

Software reads the status first and then the data. A data read removes the oldest word. If a word completes while both entries are occupied and no read frees a slot in that cycle, the block drops the new word, keeps the stored ones and raises a sticky overrun flag. A noise flag rises when a word that was flagged as noisy is accepted. Both sticky flags clear only through a status read followed directly by a data read. A level interrupt request is driven when the enable is set and either a word is waiting or an overrun is pending.

Top module: `rx_word_buffer`

## Requirements
- R1: After reset, all status outputs, `rd_data` and `irq` are 0.
- R2: Words leave in arrival order. Two words can be held at once. A completing word is accepted while the buffer is full if a data read pops an entry in the same cycle.
- R3: A word completing while both entries are full, with no pop in that cycle, sets `st_overrun` on the next cycle. The new word is discarded and the two stored words are returned unchanged by later reads.
- R4: `st_frm_err` and `st_par_err` show the bits stored with the head word, and are 0 when the buffer is empty.
- R5: `st_avail` goes to 1 the cycle after a word is accepted. It stays at 1 while any entry remains and returns to 0 when the last entry is read.
- R6: `st_noise` is set the cycle after a word with `wr_noise`=1 is accepted.
- R7: A status read without a data read arms the clear sequence. A data read while armed clears `st_overrun` and `st_noise`. A data read while not armed, or both strobes in one cycle, disarms without clearing.
- R8: `irq` is 1 exactly when `rx_irq_en` is 1 and either `st_avail` or `st_overrun` is 1. `st_noise` alone never raises it.
- R9: A data read while the buffer is empty leaves `rd_data`, `st_avail` and the stored contents unchanged.
- R10: `rd_data` is registered. It shows the popped head word from the cycle after the data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Shift register has completed a word (one-cycle strobe) |
| wr_data | input | DATA_W | Completed word |
| wr_frm_err | input | 1 | Framing error for the completed word |
| wr_par_err | input | 1 | Parity error for the completed word |
| wr_noise | input | 1 | Noise was seen while receiving the word |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rd_data | output | DATA_W | Last word read from the buffer |
| st_avail | output | 1 | At least one word is buffered |
| st_overrun | output | 1 | Sticky overrun flag |
| st_noise | output | 1 | Sticky noise flag |
| st_frm_err | output | 1 | Framing error of the head word |
| st_par_err | output | 1 | Parity error of the head word |
| irq | output | 1 | Receive interrupt request (level) |

## Verification
The first pattern sends two words that carry different error bits. It shows whether the per-word framing and parity bits follow their own word through the buffer or stick to a slot. The second pattern sends three words back to back with no reads, so that the kept words can be told apart from the dropped one. The third pattern completes a word in the same cycle as a pop while the buffer is full. This separates the pop-first rule from a plain full check. Further sequences put the strobes out of order (data read with no status read before it, both strobes together, a repeated status read, a read on an empty buffer). These show that only a true status-then-data pair clears the sticky flags, and that noise alone never requests an interrupt.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    // Error bits that travel with every buffered word
    typedef struct packed {
        logic frame;
        logic parity;
    } rxb_err_t;

    localparam rxb_err_t RXB_ERR_NONE = '{frame: 1'b0, parity: 1'b0};

    // Effect of one cycle's register accesses on the clear sequence
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_DATA   = 2'd2,
        ACC_BOTH   = 2'd3
    } rxb_access_t;

endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] in_data,
    input  rxb_err_t          in_err,
    output logic [DATA_W-1:0] head_data,
    output rxb_err_t          head_err,
    output logic              empty,
    output logic              full
);

    logic [DATA_W-1:0] slot_data [DEPTH];
    rxb_err_t          slot_err  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_data[i] <= '0;
                slot_err[i]  <= RXB_ERR_NONE;
            end else if (push && (wr_ptr == PTR_W'(i))) begin
                slot_data[i] <= in_data;
                slot_err[i]  <= in_err;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign head_data = slot_data[rd_ptr];
    assign head_err  = empty ? RXB_ERR_NONE : slot_err[rd_ptr];

endmodule

// File: rtl/rxb_flags.sv
module rxb_flags
    import rxb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stat_rd,
    input  logic data_rd,
    input  logic noise_evt,
    input  logic overrun_evt,
    output logic overrun,
    output logic noise
);

    rxb_access_t acc;
    logic        armed;
    logic        clr;

    assign acc = rxb_access_t'({data_rd, stat_rd});
    assign clr = (acc == ACC_DATA) && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else begin
            case (acc)
                ACC_STATUS: armed <= 1'b1;
                ACC_DATA,
                ACC_BOTH:   armed <= 1'b0;
                default:    armed <= armed;
            endcase
        end
    end

    // A new event in the clearing cycle wins over the clear
    always_ff @(posedge clk) begin
        if (rst) begin
            overrun <= 1'b0;
            noise   <= 1'b0;
        end else begin
            if (overrun_evt)  overrun <= 1'b1;
            else if (clr)     overrun <= 1'b0;
            if (noise_evt)    noise   <= 1'b1;
            else if (clr)     noise   <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_word_buffer.sv
module rx_word_buffer
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_frm_err,
    input  logic              wr_par_err,
    input  logic              wr_noise,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              rx_irq_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              st_avail,
    output logic              st_overrun,
    output logic              st_noise,
    output logic              st_frm_err,
    output logic              st_par_err,
    output logic              irq
);

    logic              fifo_empty;
    logic              fifo_full;
    logic              pop;
    logic              push;
    logic              overrun_evt;
    logic [DATA_W-1:0] head_data;
    rxb_err_t          head_err;
    rxb_err_t          in_err;

    assign in_err      = '{frame: wr_frm_err, parity: wr_par_err};
    assign pop         = data_rd && !fifo_empty;
    assign push        = wr_valid && (!fifo_full || pop);
    assign overrun_evt = wr_valid && fifo_full && !pop;

    rxb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .in_data   (wr_data),
        .in_err    (in_err),
        .head_data (head_data),
        .head_err  (head_err),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    rxb_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .stat_rd     (stat_rd),
        .data_rd     (data_rd),
        .noise_evt   (push && wr_noise),
        .overrun_evt (overrun_evt),
        .overrun     (st_overrun),
        .noise       (st_noise)
    );

    always_ff @(posedge clk) begin
        if (rst)      rd_data <= '0;
        else if (pop) rd_data <= head_data;
    end

    assign st_avail   = !fifo_empty;
    assign st_frm_err = head_err.frame;
    assign st_par_err = head_err.parity;
    assign irq        = rx_irq_en && (st_avail || st_overrun);

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              data_rd,
    input logic              rx_irq_en,
    input logic              fifo_full,
    input logic              st_avail,
    input logic              st_overrun,
    input logic              st_frm_err,
    input logic              st_par_err,
    input logic              irq,
    input logic [DATA_W-1:0] rd_data
);

    a_r3_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && fifo_full && !data_rd) |=> st_overrun);

    a_r4_empty_no_err: assert property (@(posedge clk) disable iff (rst)
        !st_avail |-> (!st_frm_err && !st_par_err));

    a_r5_avail_after_push: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !fifo_full) |=> st_avail);

    a_r7_clear_by_read: assert property (@(posedge clk) disable iff (rst)
        $fell(st_overrun) |-> $past(data_rd));

    a_r8_no_irq_masked: assert property (@(posedge clk) disable iff (rst)
        !rx_irq_en |-> !irq);

    a_r8_overrun_irq: assert property (@(posedge clk) disable iff (rst)
        (rx_irq_en && st_overrun) |-> irq);

    a_r9_empty_read_hold: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !st_avail && !wr_valid) |=> ($stable(rd_data) && !st_avail));

endmodule

bind rx_word_buffer rxb_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .data_rd    (data_rd),
    .rx_irq_en  (rx_irq_en),
    .fifo_full  (fifo_full),
    .st_avail   (st_avail),
    .st_overrun (st_overrun),
    .st_frm_err (st_frm_err),
    .st_par_err (st_par_err),
    .irq        (irq),
    .rd_data    (rd_data)
);

// File: tb/tb_rx_word_buffer.sv
module tb_rx_word_buffer;

    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_valid, wr_frm_err, wr_par_err, wr_noise;
    logic [DATA_W-1:0] wr_data;
    logic              stat_rd, data_rd, rx_irq_en;
    logic [DATA_W-1:0] rd_data;
    logic              st_avail, st_overrun, st_noise, st_frm_err, st_par_err, irq;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    rx_word_buffer #(.DATA_W(DATA_W), .DEPTH(2)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_frm_err(wr_frm_err), .wr_par_err(wr_par_err), .wr_noise(wr_noise),
        .stat_rd(stat_rd), .data_rd(data_rd), .rx_irq_en(rx_irq_en),
        .rd_data(rd_data), .st_avail(st_avail), .st_overrun(st_overrun),
        .st_noise(st_noise), .st_frm_err(st_frm_err), .st_par_err(st_par_err),
        .irq(irq)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic eq(input int act, input int exp, input string req);
        check(act == exp, req, act, exp);
    endtask

    // Drive one cycle of stimulus at a falling edge; outputs settle by the next one
    task automatic cyc(input logic wv, input logic [DATA_W-1:0] d, input logic f,
                       input logic p, input logic n, input logic sr, input logic dr);
        wr_valid = wv; wr_data = d; wr_frm_err = f; wr_par_err = p; wr_noise = n;
        stat_rd = sr; data_rd = dr;
        @(negedge clk);
        wr_valid = 1'b0; wr_frm_err = 1'b0; wr_par_err = 1'b0; wr_noise = 1'b0;
        stat_rd = 1'b0; data_rd = 1'b0;
    endtask

    task automatic push(input logic [DATA_W-1:0] d, input logic f, input logic p, input logic n);
        cyc(1'b1, d, f, p, n, 1'b0, 1'b0);
    endtask

    task automatic rd_stat();
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic rd_data_reg();
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        eq(rd_data, 0, "R1 rd_data");
        eq({st_avail, st_overrun, st_noise, st_frm_err, st_par_err}, 0, "R1 status");
        eq(irq, 0, "R1 irq");
    endtask

    task automatic t_order_and_errors();
        push(8'hA1, 1'b1, 1'b0, 1'b0);
        eq(st_avail, 1, "R5 avail after push");
        push(8'hB2, 1'b0, 1'b1, 1'b0);
        eq({st_frm_err, st_par_err}, 2'b10, "R4 head errs first word");
        rd_stat(); rd_data_reg();
        eq(rd_data, 8'hA1, "R2 first out");
        eq(rd_data, 8'hA1, "R10 registered data");
        eq({st_frm_err, st_par_err}, 2'b01, "R4 head errs second word");
        eq(st_avail, 1, "R5 avail with one left");
        rd_stat(); rd_data_reg();
        eq(rd_data, 8'hB2, "R2 second out");
        eq(st_avail, 0, "R5 avail after last read");
        eq({st_frm_err, st_par_err}, 2'b00, "R4 empty errs zero");
    endtask

    task automatic t_overrun();
        rx_irq_en = 1'b1;
        push(8'hC3, 1'b0, 1'b0, 1'b0);
        push(8'hD4, 1'b0, 1'b0, 1'b0);
        eq(st_overrun, 0, "R3 no overrun at two");
        push(8'hE5, 1'b1, 1'b1, 1'b0);
        eq(st_overrun, 1, "R3 overrun set");
        eq(irq, 1, "R8 irq with overrun");
        rd_data_reg();
        eq(rd_data, 8'hC3, "R3 kept first");
        rd_data_reg();
        eq(rd_data, 8'hD4, "R3 kept second");
        eq(st_avail, 0, "R3 third word dropped");
        eq(st_overrun, 1, "R7 overrun stays without status read");
        eq(irq, 1, "R8 irq from overrun only");
        rd_stat(); rd_data_reg();
        eq(st_overrun, 0, "R7 overrun cleared by sequence");
        eq(rd_data, 8'hD4, "R9 empty read keeps data");
        eq(irq, 0, "R8 irq low after clear");
        rx_irq_en = 1'b0;
    endtask

    task automatic t_push_with_pop();
        push(8'h11, 1'b0, 1'b0, 1'b0);
        push(8'h22, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        eq(rd_data, 8'h11, "R2 pop while full");
        eq(st_overrun, 0, "R2 no overrun with same-cycle pop");
        rd_data_reg();
        eq(rd_data, 8'h22, "R2 second after pop");
        rd_data_reg();
        eq(rd_data, 8'h33, "R2 word accepted during pop");
        eq(st_avail, 0, "R5 empty again");
    endtask

    task automatic t_noise_and_arm();
        push(8'h5A, 1'b0, 1'b0, 1'b1);
        eq(st_noise, 1, "R6 noise set");
        eq(irq, 0, "R8 masked irq");
        rx_irq_en = 1'b1;
        @(negedge clk);
        eq(irq, 1, "R8 irq from avail");
        rd_data_reg();
        eq(st_noise, 1, "R7 no clear without status read");
        eq(irq, 0, "R8 noise alone no irq");
        rd_stat();
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        eq(st_noise, 1, "R7 both strobes no clear");
        rd_data_reg();
        eq(st_noise, 1, "R7 disarmed after both strobes");
        rd_stat(); rd_stat(); rd_data_reg();
        eq(st_noise, 0, "R7 clear after repeated status read");
        rx_irq_en = 1'b0;
    endtask

    task automatic t_empty_read();
        rd_data_reg();
        eq(rd_data, 8'h5A, "R9 rd_data held on empty read");
        eq(st_avail, 0, "R9 still empty");
        push(8'h77, 1'b0, 1'b0, 1'b0);
        rd_data_reg();
        eq(rd_data, 8'h77, "R9 pointers intact after empty read");
        eq(st_avail, 0, "R9 empty after single read");
    endtask

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_data = '0; wr_frm_err = 1'b0;
        wr_par_err = 1'b0; wr_noise = 1'b0; stat_rd = 1'b0; data_rd = 1'b0;
        rx_irq_en = 1'b0;
        @(negedge clk);
        t_reset();
        t_order_and_errors();
        t_overrun();
        t_push_with_pop();
        t_noise_and_arm();
        t_empty_read();
        push(8'h99, 1'b1, 1'b0, 1'b1);
        t_reset();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule